// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps a set of private, write-back, direct-mapped caches coherent for a small multicore cluster. Each core has its own one-word-per-line cache that tracks every line in one of four states: Invalid, Shared, Exclusive or Modified. A backing word memory sits behind the caches. Hits are served inside the core's cache without touching the shared bus. Misses, and writes to Shared lines, compete for one serial snoop bus. On that bus every other cache looks up the address and answers on two wired-OR lines. One line says whether any peer holds a copy. The other says whether that copy is dirty.

Each core issues requests on a valid/ready channel. A request is taken on the rising edge where both `req_valid` and `req_ready` are high. The core must hold address, data and direction stable while valid is high and ready is low. `req_ready` stays low until the reply comes back. The reply is a single-cycle `rsp_valid` pulse with no back-pressure, so the core takes it in that cycle. The snoop bus itself is brought out as plain observation outputs.

A bus tenure lasts one clock. In that clock the requester is granted, the peers answer and update their states, and memory takes any write-back. The requester installs the line and its reply is registered.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` then stays low until exactly one `rsp_valid` pulse arrives. For a read the pulse carries the line data, and for a write it carries the written value. A local hit replies on the second edge after acceptance, and an uncontended bus access replies on the third.
- R2: After reset every line is Invalid, all `req_ready` bits are high, no `rsp_valid` is high and the bus is idle. Memory word a holds a XOR MEM_SEED, where MEM_SEED defaults to 0x5A.
- R3: A read that hits a line in Modified, Exclusive or Shared returns the cached word with no bus tenure and no state change.
- R4: A read miss issues bus command 1 (shared read). If no peer holds the line, the word comes from memory and the line becomes Exclusive. If peers hold it clean, one of them supplies the word and the line becomes Shared.
- R5: If a read miss finds the line Modified in a peer, that peer supplies the word and writes it back to memory in the same tenure. Both copies end Shared.
- R6: A write hit on Modified or Exclusive updates the word locally and leaves the line Modified, with no bus tenure.
- R7: A write hit on Shared issues bus command 3 (invalidate). Every peer copy goes Invalid and the writer's line becomes Modified.
- R8: A write miss issues bus command 2 (read for ownership). Any Modified peer writes back, and every peer copy goes Invalid. The writer installs the line Modified with the write data.
- R9: When a miss replaces a line of a different address that is Modified, that line is written back to memory in the same tenure before it is lost.
- R10: At most one core is granted per cycle. Grants rotate round-robin, starting from the core after the last one granted.
- R11: `bus_shared` is high in a tenure when any other cache holds the address, and `bus_dirty` is high when that copy is Modified. Both lines are low when the bus is idle.
- R12: At no time does a cache hold a line in Modified or Exclusive while another cache holds a valid copy of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORES | Request valid, one bit per core |
| req_ready | output | NCORES | Request ready, one bit per core |
| req_write | input | NCORES | 1 = write, 0 = read, per core |
| req_addr | input | NCORES*ADDR_W | Word address, core i in bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | NCORES*DATA_W | Write data, core i in bits [i*DATA_W +: DATA_W] |
| rsp_valid | output | NCORES | Single-cycle reply pulse per core |
| rsp_rdata | output | NCORES*DATA_W | Reply data, core i in bits [i*DATA_W +: DATA_W] |
| bus_valid | output | 1 | A bus tenure takes place this cycle |
| bus_core | output | $clog2(NCORES) | Index of the granted core |
| bus_cmd | output | 2 | 1 shared read, 2 read for ownership, 3 invalidate |
| bus_addr | output | ADDR_W | Address of the tenure |
| bus_shared | output | 1 | Wired-OR: a peer holds the address |
| bus_dirty | output | 1 | Wired-OR: a peer holds it Modified |

## Verification
The checks assume that every core keeps its request fields steady from the cycle it raises `req_valid` until that request is taken. They also assume that a core raises no new request before its previous reply has arrived. The stimulus keeps to these rules. Each access is driven on a falling edge, and the bench lowers valid right after acceptance and waits for the reply pulse before the next access from that core. The stimulus makes the bus lines meaningful by preparing each line in a known state through the earlier steps. It also issues four simultaneous requests to one address. That exercises the rotation and the effect of each tenure on the next one's snoop answers.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_E = 2'd2,
    LN_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPG  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_nxt;
  logic             found;

  // first requester at or after the pointer wins
  always_comb begin
    gnt     = '0;
    found   = 1'b0;
    ptr_nxt = ptr_q;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!found && req[j]) begin
        gnt[j]  = 1'b1;
        found   = 1'b1;
        ptr_nxt = PTR_W'((j + 1) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (found) ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/mesi_mem.sv
module mesi_mem #(
  parameter int              ADDR_W = 5,
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] SEED = 'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[rd_addr];

  // port a: snoop write-back, port b: victim write-back (never the same word)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i) ^ SEED;
    end else begin
      if (wa_en) mem_q[wa_addr] <= wa_data;
      if (wb_en) mem_q[wb_addr] <= wb_data;
    end
  end
endmodule

// File: rtl/mesi_cache_node.sv
module mesi_cache_node
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  // core side
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_rdata,
  // requester side of the bus
  output logic                         bus_req,
  input  logic                         bus_gnt,
  output bus_cmd_e                     own_cmd,
  output logic [ADDR_W-1:0]            own_addr,
  output logic                         victim_wb,
  output logic [ADDR_W-1:0]            victim_addr,
  output logic [DATA_W-1:0]            victim_data,
  input  logic [DATA_W-1:0]            fill_data,
  input  logic                         fill_shared,
  // snooper side of the bus
  input  logic                         snp_valid,
  input  bus_cmd_e                     snp_cmd,
  input  logic [ADDR_W-1:0]            snp_addr,
  output logic                         snp_shared,
  output logic                         snp_dirty,
  output logic [DATA_W-1:0]            snp_data,
  // line state view for the checker
  output logic [NLINES-1:0][1:0]       state_o,
  output logic [NLINES-1:0][ADDR_W-$clog2(NLINES)-1:0] tag_o
);
  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {CN_IDLE, CN_LOOK, CN_BUS} cn_fsm_e;

  cn_fsm_e           fsm_q;
  line_st_e          st_q  [NLINES];
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [DATA_W-1:0] dat_q [NLINES];

  logic              r_write_q;
  logic [ADDR_W-1:0] r_addr_q;
  logic [DATA_W-1:0] r_wdata_q;

  logic [IDX_W-1:0]  idx, sidx;
  logic [TAG_W-1:0]  tg, stg;
  logic              hit, local_ok, clash, s_hit;

  for (genvar l = 0; l < NLINES; l++) begin : g_view
    assign state_o[l] = st_q[l];
    assign tag_o[l]   = tag_q[l];
  end

  assign req_ready = (fsm_q == CN_IDLE);
  assign own_addr  = r_addr_q;

  // request-side lookup
  always_comb begin
    idx      = r_addr_q[IDX_W-1:0];
    tg       = r_addr_q[ADDR_W-1:IDX_W];
    hit      = (st_q[idx] != LN_I) && (tag_q[idx] == tg);
    local_ok = hit && (!r_write_q || st_q[idx] == LN_E || st_q[idx] == LN_M);
    // a snoop on the same set this cycle wins; the lookup retries next cycle
    clash    = snp_valid && (snp_addr[IDX_W-1:0] == idx);
    bus_req  = (fsm_q == CN_BUS);
    if (!r_write_q)  own_cmd = BC_RD;
    else if (hit)    own_cmd = BC_UPG;
    else             own_cmd = BC_RDX;
    victim_wb   = (fsm_q == CN_BUS) && (st_q[idx] == LN_M) && (tag_q[idx] != tg);
    victim_addr = {tag_q[idx], idx};
    victim_data = dat_q[idx];
  end

  // snoop-side lookup
  always_comb begin
    sidx       = snp_addr[IDX_W-1:0];
    stg        = snp_addr[ADDR_W-1:IDX_W];
    s_hit      = snp_valid && (st_q[sidx] != LN_I) && (tag_q[sidx] == stg);
    snp_shared = s_hit;
    snp_dirty  = s_hit && (st_q[sidx] == LN_M);
    snp_data   = s_hit ? dat_q[sidx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= CN_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      r_write_q <= 1'b0;
      r_addr_q  <= '0;
      r_wdata_q <= '0;
      for (int l = 0; l < NLINES; l++) begin
        st_q[l]  <= LN_I;
        tag_q[l] <= '0;
        dat_q[l] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (s_hit) begin
        if (snp_cmd == BC_RD) st_q[sidx] <= LN_S;
        else                  st_q[sidx] <= LN_I;
      end
      case (fsm_q)
        CN_IDLE: begin
          if (req_valid) begin
            r_write_q <= req_write;
            r_addr_q  <= req_addr;
            r_wdata_q <= req_wdata;
            fsm_q     <= CN_LOOK;
          end
        end
        CN_LOOK: begin
          if (!clash) begin
            if (local_ok) begin
              if (r_write_q) begin
                dat_q[idx] <= r_wdata_q;
                st_q[idx]  <= LN_M;
                rsp_rdata  <= r_wdata_q;
              end else begin
                rsp_rdata  <= dat_q[idx];
              end
              rsp_valid <= 1'b1;
              fsm_q     <= CN_IDLE;
            end else begin
              fsm_q <= CN_BUS;
            end
          end
        end
        CN_BUS: begin
          if (bus_gnt) begin
            tag_q[idx] <= tg;
            dat_q[idx] <= r_write_q ? r_wdata_q : fill_data;
            rsp_rdata  <= r_write_q ? r_wdata_q : fill_data;
            if (r_write_q)        st_q[idx] <= LN_M;
            else if (fill_shared) st_q[idx] <= LN_S;
            else                  st_q[idx] <= LN_E;
            rsp_valid <= 1'b1;
            fsm_q     <= CN_IDLE;
          end
        end
        default: fsm_q <= CN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int                NCORES   = 4,
  parameter int                NLINES   = 4,
  parameter int                ADDR_W   = 5,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] MEM_SEED = 'h5A
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCORES-1:0]          req_valid,
  output logic [NCORES-1:0]          req_ready,
  input  logic [NCORES-1:0]          req_write,
  input  logic [NCORES*ADDR_W-1:0]   req_addr,
  input  logic [NCORES*DATA_W-1:0]   req_wdata,
  output logic [NCORES-1:0]          rsp_valid,
  output logic [NCORES*DATA_W-1:0]   rsp_rdata,
  output logic                       bus_valid,
  output logic [$clog2(NCORES)-1:0]  bus_core,
  output logic [1:0]                 bus_cmd,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic                       bus_shared,
  output logic                       bus_dirty
);
  localparam int CID_W = $clog2(NCORES);
  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [NCORES-1:0]       creq, gnt, vic_wb, snp_valid, snp_sh, snp_dt;
  bus_cmd_e                own_cmd  [NCORES];
  logic [ADDR_W-1:0]       own_addr [NCORES];
  logic [ADDR_W-1:0]       vic_addr [NCORES];
  logic [DATA_W-1:0]       vic_data [NCORES];
  logic [DATA_W-1:0]       snp_data [NCORES];
  logic [NCORES-1:0][NLINES-1:0][1:0]       st_all;
  logic [NCORES-1:0][NLINES-1:0][TAG_W-1:0] tag_all;

  bus_cmd_e          sel_cmd;
  logic [ADDR_W-1:0] sel_addr, sel_vic_addr;
  logic [DATA_W-1:0] sel_vic_data, snp_or, mem_rdata, fill_data;
  logic              sel_vic_wb;
  logic [CID_W-1:0]  sel_core;

  mesi_rr_arb #(.N(NCORES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(creq), .gnt(gnt)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    assign snp_valid[g] = bus_valid && !gnt[g];

    mesi_cache_node #(.NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_node (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[g]),
      .req_ready  (req_ready[g]),
      .req_write  (req_write[g]),
      .req_addr   (req_addr[g*ADDR_W +: ADDR_W]),
      .req_wdata  (req_wdata[g*DATA_W +: DATA_W]),
      .rsp_valid  (rsp_valid[g]),
      .rsp_rdata  (rsp_rdata[g*DATA_W +: DATA_W]),
      .bus_req    (creq[g]),
      .bus_gnt    (gnt[g]),
      .own_cmd    (own_cmd[g]),
      .own_addr   (own_addr[g]),
      .victim_wb  (vic_wb[g]),
      .victim_addr(vic_addr[g]),
      .victim_data(vic_data[g]),
      .fill_data  (fill_data),
      .fill_shared(bus_shared),
      .snp_valid  (snp_valid[g]),
      .snp_cmd    (sel_cmd),
      .snp_addr   (sel_addr),
      .snp_shared (snp_sh[g]),
      .snp_dirty  (snp_dt[g]),
      .snp_data   (snp_data[g]),
      .state_o    (st_all[g]),
      .tag_o      (tag_all[g])
    );
  end

  // granted-core mux and wired-OR of the snoop answers
  always_comb begin
    sel_cmd      = BC_IDLE;
    sel_addr     = '0;
    sel_core     = '0;
    sel_vic_wb   = 1'b0;
    sel_vic_addr = '0;
    sel_vic_data = '0;
    snp_or       = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (gnt[i]) begin
        sel_cmd      = own_cmd[i];
        sel_addr     = own_addr[i];
        sel_core     = CID_W'(i);
        sel_vic_wb   = vic_wb[i];
        sel_vic_addr = vic_addr[i];
        sel_vic_data = vic_data[i];
      end
      snp_or = snp_or | snp_data[i];
    end
  end

  assign bus_valid  = |gnt;
  assign bus_core   = sel_core;
  assign bus_cmd    = sel_cmd;
  assign bus_addr   = sel_addr;
  assign bus_shared = |snp_sh;
  assign bus_dirty  = |snp_dt;

  // peer data for shared reads and dirty lines; memory otherwise
  assign fill_data = (bus_dirty || (sel_cmd == BC_RD && bus_shared)) ? snp_or : mem_rdata;

  mesi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(MEM_SEED)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(sel_addr),
    .rd_data(mem_rdata),
    .wa_en  (bus_dirty),
    .wa_addr(sel_addr),
    .wa_data(snp_or),
    .wb_en  (sel_vic_wb),
    .wb_addr(sel_vic_addr),
    .wb_data(sel_vic_data)
  );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int NCORES = 4,
  parameter int NLINES = 4,
  parameter int ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCORES-1:0]        gnt,
  input logic [NCORES-1:0]        req_valid,
  input logic [NCORES-1:0]        req_ready,
  input logic                     bus_valid,
  input logic [1:0]               bus_cmd,
  input logic                     bus_shared,
  input logic                     bus_dirty,
  input logic [NCORES-1:0][NLINES-1:0][1:0] st_all,
  input logic [NCORES-1:0][NLINES-1:0][ADDR_W-$clog2(NLINES)-1:0] tag_all
);
  logic excl_viol;

  always_comb begin
    excl_viol = 1'b0;
    for (int l = 0; l < NLINES; l++)
      for (int a = 0; a < NCORES; a++)
        for (int b = 0; b < NCORES; b++)
          if (a != b && st_all[a][l][1] && st_all[b][l] != 2'd0 &&
              tag_all[a][l] == tag_all[b][l])
            excl_viol = 1'b1;
  end

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) !excl_viol); // R12
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R10
  AST_DIRTY_HAS_COPY: assert property (@(posedge clk) disable iff (!rst_n) bus_dirty |-> bus_shared); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !bus_valid |-> (!bus_shared && !bus_dirty)); // R11
  AST_CMD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n) bus_valid |-> (bus_cmd != 2'd0)); // R10
  AST_UPG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && bus_cmd == 2'd3) |-> !bus_dirty); // R7

  for (genvar c = 0; c < NCORES; c++) begin : g_hs
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid[c] && req_ready[c]) |=> !req_ready[c]); // R1
  end
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(
  .NCORES(NCORES), .NLINES(NLINES), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt       (gnt),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_cmd   (bus_cmd),
  .bus_shared(bus_shared),
  .bus_dirty (bus_dirty),
  .st_all    (st_all),
  .tag_all   (tag_all)
);

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int AW = 5;
  localparam int DW = 8;

  typedef struct packed {
    logic [1:0] core;
    logic       wr;
    logic [4:0] addr;
    logic [7:0] wdata;
    logic [7:0] edata;
    logic [1:0] ecmd;
    logic       esh;
    logic       edt;
    logic [3:0] req;
  } vec_t;

  // memory word a starts as a ^ 0x5A; line index = addr[1:0]
  localparam vec_t VEC [16] = '{
    '{2'd0, 1'b0, 5'd4,  8'h00, 8'h5E, 2'd1, 1'b0, 1'b0, 4'd4},  // R4 miss, no holder
    '{2'd0, 1'b0, 5'd4,  8'h00, 8'h5E, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 hit on E
    '{2'd0, 1'b1, 5'd4,  8'h11, 8'h11, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 E -> M silent
    '{2'd1, 1'b0, 5'd4,  8'h00, 8'h11, 2'd1, 1'b1, 1'b1, 4'd5},  // R5 peer M
    '{2'd2, 1'b0, 5'd4,  8'h00, 8'h11, 2'd1, 1'b1, 1'b0, 4'd4},  // R4 peers S
    '{2'd1, 1'b1, 5'd4,  8'h22, 8'h22, 2'd3, 1'b1, 1'b0, 4'd7},  // R7 S upgrade
    '{2'd0, 1'b0, 5'd4,  8'h00, 8'h22, 2'd1, 1'b1, 1'b1, 4'd5},  // R5
    '{2'd3, 1'b1, 5'd4,  8'h33, 8'h33, 2'd2, 1'b1, 1'b0, 4'd8},  // R8 clean holders
    '{2'd2, 1'b1, 5'd4,  8'h44, 8'h44, 2'd2, 1'b1, 1'b1, 4'd8},  // R8 M holder
    '{2'd0, 1'b0, 5'd4,  8'h00, 8'h44, 2'd1, 1'b1, 1'b1, 4'd5},  // R5
    '{2'd1, 1'b1, 5'd9,  8'h55, 8'h55, 2'd2, 1'b0, 1'b0, 4'd8},  // R8 no holder
    '{2'd1, 1'b0, 5'd9,  8'h00, 8'h55, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 hit on M
    '{2'd1, 1'b0, 5'd13, 8'h00, 8'h57, 2'd1, 1'b0, 1'b0, 4'd9},  // R9 dirty victim
    '{2'd2, 1'b0, 5'd9,  8'h00, 8'h55, 2'd1, 1'b0, 1'b0, 4'd9},  // R9 victim reached memory
    '{2'd2, 1'b1, 5'd9,  8'h66, 8'h66, 2'd0, 1'b0, 1'b0, 4'd6},  // R6
    '{2'd3, 1'b0, 5'd2,  8'h00, 8'h58, 2'd1, 1'b0, 1'b0, 4'd4}   // R4
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_ready;
  logic [NC-1:0]    req_write = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC*DW-1:0] req_wdata = '0;
  logic [NC-1:0]    rsp_valid;
  logic [NC*DW-1:0] rsp_rdata;
  logic             bus_valid;
  logic [1:0]       bus_core;
  logic [1:0]       bus_cmd;
  logic [AW-1:0]    bus_addr;
  logic             bus_shared;
  logic             bus_dirty;

  int checks = 0;
  int errors = 0;

  int         log_n = 0;
  logic [1:0] log_core [256];
  logic [1:0] log_cmd  [256];
  logic       log_sh   [256];
  logic       log_dt   [256];

  mesi_snoop_ctrl u_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_core(bus_core), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_shared(bus_shared), .bus_dirty(bus_dirty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus monitor, mid-cycle
  always @(negedge clk) begin
    if (rst_n && bus_valid) begin
      log_core[log_n % 256] = bus_core;
      log_cmd[log_n % 256]  = bus_cmd;
      log_sh[log_n % 256]   = bus_shared;
      log_dt[log_n % 256]   = bus_dirty;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int c, input bit wr, input logic [4:0] addr,
                        input logic [7:0] wd, output logic [7:0] rd,
                        output int ntx, output logic [1:0] cmd,
                        output logic sh, output logic dt, output int lat);
    int base;
    int guard = 0;
    while (!req_ready[c] && guard < 100) begin @(negedge clk); guard++; end
    base = log_n;
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*AW +: AW] = addr;
    req_wdata[c*DW +: DW] = wd;
    @(negedge clk);
    req_valid[c] = 1'b0;
    check(req_ready[c] == 1'b0, "R1", "ready low after accept", req_ready[c], 0);
    lat = 0;
    while (!rsp_valid[c] && lat < 100) begin @(negedge clk); lat++; end
    rd = rsp_rdata[c*DW +: DW];
    ntx = 0; cmd = 2'd0; sh = 1'b0; dt = 1'b0;
    for (int k = base; k < log_n; k++) begin
      if (log_core[k % 256] == 2'(c)) begin
        ntx++;
        cmd = log_cmd[k % 256];
        sh  = log_sh[k % 256];
        dt  = log_dt[k % 256];
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [1:0] cmd;
    logic       sh, dt;
    int         ntx, lat;
    string      tag;

    repeat (3) @(negedge clk);
    // R2 reset state
    check(req_ready == 4'hF, "R2", "ready in reset", req_ready, 4'hF);
    check(rsp_valid == 4'h0, "R2", "rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_valid == 1'b0, "R2", "bus idle after reset", bus_valid, 0);
    check(req_ready == 4'hF, "R2", "ready after reset", req_ready, 4'hF);

    // vector walk
    for (int v = 0; v < 16; v++) begin
      vec_t t;
      t = VEC[v];
      tag = $sformatf("R%0d v%0d", t.req, v);
      access(int'(t.core), t.wr, t.addr, t.wdata, rd, ntx, cmd, sh, dt, lat);
      check(rd == t.edata, tag, "reply data", rd, t.edata);
      check(ntx == ((t.ecmd != 2'd0) ? 1 : 0), tag, "tenures", ntx, (t.ecmd != 2'd0) ? 1 : 0);
      check(lat == ((t.ecmd != 2'd0) ? 2 : 1), "R1", "reply latency", lat, (t.ecmd != 2'd0) ? 2 : 1);
      if (t.ecmd != 2'd0) begin
        check(cmd == t.ecmd, tag, "bus command", cmd, t.ecmd);
        check(sh == t.esh, "R11", "shared answer", sh, t.esh);
        check(dt == t.edt, "R11", "dirty answer", dt, t.edt);
      end
    end

    // R10: four simultaneous reads of address 20; rotation starts at core 0
    begin
      int base;
      int got;
      logic [NC-1:0] seen;
      base = log_n;
      seen = '0;
      got = 0;
      for (int c = 0; c < NC; c++) begin
        req_write[c] = 1'b0;
        req_addr[c*AW +: AW] = 5'd20;
      end
      req_valid = 4'hF;
      @(negedge clk);
      req_valid = 4'h0;
      for (int w = 0; w < 20 && seen != 4'hF; w++) begin
        @(negedge clk);
        for (int c = 0; c < NC; c++) if (rsp_valid[c]) begin
          seen[c] = 1'b1;
          check(rsp_rdata[c*DW +: DW] == 8'h4E, "R4", "parallel read data", rsp_rdata[c*DW +: DW], 8'h4E);
        end
      end
      check(seen == 4'hF, "R1", "all replies", seen, 4'hF);
      check(log_n - base == 4, "R10", "tenure count", log_n - base, 4);
      for (int k = 0; k < 4; k++) begin
        check(log_core[(base + k) % 256] == 2'(k), "R10", "grant order", log_core[(base + k) % 256], k);
        check(log_sh[(base + k) % 256] == (k != 0), "R4", "shared on parallel read", log_sh[(base + k) % 256], k != 0);
      end
      got = base;

      // R7/R8: four simultaneous writes to the same Shared line
      base = log_n;
      seen = '0;
      for (int c = 0; c < NC; c++) begin
        req_write[c] = 1'b1;
        req_wdata[c*DW +: DW] = 8'hA0 + 8'(c);
      end
      req_valid = 4'hF;
      @(negedge clk);
      req_valid = 4'h0;
      for (int w = 0; w < 20 && seen != 4'hF; w++) begin
        @(negedge clk);
        for (int c = 0; c < NC; c++) if (rsp_valid[c]) begin
          seen[c] = 1'b1;
          check(rsp_rdata[c*DW +: DW] == 8'hA0 + 8'(c), "R1", "write reply", rsp_rdata[c*DW +: DW], 8'hA0 + c);
        end
      end
      check(log_n - base == 4, "R10", "write tenures", log_n - base, 4);
      check(log_cmd[base % 256] == 2'd3, "R7", "first writer upgrades", log_cmd[base % 256], 3);
      for (int k = 1; k < 4; k++) begin
        check(log_cmd[(base + k) % 256] == 2'd2, "R8", "later writers own-read", log_cmd[(base + k) % 256], 2);
        check(log_dt[(base + k) % 256] == 1'b1, "R8", "previous writer dirty", log_dt[(base + k) % 256], 1);
      end
      if (got < 0) $display("unreachable");
    end

    access(0, 1'b0, 5'd20, 8'h00, rd, ntx, cmd, sh, dt, lat);
    check(rd == 8'hA3, "R5", "read after last writer", rd, 8'hA3);
    check(dt == 1'b1, "R5", "dirty owner answers", dt, 1);
    access(1, 1'b0, 5'd20, 8'h00, rd, ntx, cmd, sh, dt, lat);
    check(rd == 8'hA3, "R4", "read from sharers", rd, 8'hA3);
    check(sh == 1'b1 && dt == 1'b0, "R11", "clean sharers answer", {sh, dt}, 2'b10);
    access(1, 1'b0, 5'd20, 8'h00, rd, ntx, cmd, sh, dt, lat);
    check(ntx == 0 && rd == 8'hA3, "R3", "hit on Shared", ntx, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule